// File: doc/BRIEF.md
# Auto-Masking Priority Interrupt Controller

This block gathers a bank of level-sensitive hardware interrupt lines, each paired with a software trigger bit, and keeps one mask bit per line. A line is a live source while its hardware level or its software bit is high and its mask bit is clear. Among the live sources, the one with the lowest index is the winner. A single event register reports the winner.

Reading the event register both delivers the winner and acknowledges it. In the same access the controller sets the winner's mask bit, so the line cannot be delivered again until software clears that bit. Software sets and clears mask and trigger bits through separate write-one-to-act registers. One output tells the CPU that at least one live source exists.

The output is driven by a two-state machine. `ST_QUIET` means no live source was seen at the last edge, and `ST_ALERT` means one was. The transition `QUIET_TO_ALERT` is taken when any live source exists. `ALERT_TO_QUIET` is taken when none remains. The machine holds its state otherwise (`QUIET_HOLD`, `ALERT_HOLD`).

Top module: `auto_mask_intc`

## Requirements
- R1: After reset every mask bit reads 1, every software trigger bit reads 0, `cpu_irq` is 0 and `rsp_valid` is 0.
- R2: A line's raw request is its hardware level ORed with its software trigger bit, and it is evaluated as a level: when both drop, the line is no longer a source.
- R3: A line whose mask bit is 1 never makes `cpu_irq` rise and is never reported by an event read.
- R4: When several unmasked lines are raw-requesting, an event read reports the lowest-numbered one.
- R5: Any read returns its data on `rsp_data` with `rsp_valid` high in the cycle after the request. The event word carries a type in bits [31:28] (0 = none, 1 = hardware line, 2 = fast interrupt, which this block never produces), the die identifier parameter in bits [27:24], and the line index in bits [15:0]. All other bits are 0.
- R6: An event read that reports a line sets that line's mask bit. The bit reads 1 from the next cycle on.
- R7: An event read with no live source returns all zeros and changes no mask bit.
- R8: `cpu_irq` equals the OR of all live sources in the previous cycle. That is, it follows them one clock later.
- R9: Address 1 sets mask bits and address 2 clears them. Address 3 sets software trigger bits and address 4 clears them. Each write acts only on bits written as 1, and 0 bits have no effect. A read at address 1 or 2 returns the mask vector. A read at address 3 or 4 returns the trigger vector. Address 0 is the event register.
- R10: Clearing the mask of a line whose raw request is still high makes that line a live source again: `cpu_irq` is high one cycle after the clear, and the next event read reports the line if it is the lowest live source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NUM_LINES | Level-sensitive hardware request lines |
| req | input | 1 | Register access strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| cpu_irq | output | 1 | Event-pending signal to the CPU |

## Verification
A corrupted mask or trigger bit appears at the next read of its register. It also shows as a wrong `cpu_irq` level one cycle after it would have changed the set of live sources. A wrong priority or a missed auto-mask appears in the word of the very read that delivers it, or in the second of two back-to-back event reads. A fault in the output state machine shows up as a mismatch on `cpu_irq` in the cycle right after the live-source set changes.

// File: rtl/aimc_pkg.sv
package aimc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_EVENT    = 3'd0,
        RA_MASK_SET = 3'd1,
        RA_MASK_CLR = 3'd2,
        RA_SW_SET   = 3'd3,
        RA_SW_CLR   = 3'd4
    } reg_addr_e;

    typedef enum logic [3:0] {
        EV_NONE = 4'd0,
        EV_HW   = 4'd1,
        EV_FAST = 4'd2
    } ev_type_e;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } irq_state_e;

    typedef struct packed {
        ev_type_e    kind;
        logic [3:0]  die;
        logic [7:0]  rsvd;
        logic [15:0] line;
    } ev_word_t;

endpackage

// File: rtl/aimc_line_bank.sv
module aimc_line_bank #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] mask_set,
    input  logic [NUM_LINES-1:0] mask_clr,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] sw_clr,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] sw_q
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b1;
                sw_q[g]   <= 1'b0;
            end else begin
                if (mask_set[g]) begin
                    mask_q[g] <= 1'b1;
                end else if (mask_clr[g]) begin
                    mask_q[g] <= 1'b0;
                end
                if (sw_set[g]) begin
                    sw_q[g] <= 1'b1;
                end else if (sw_clr[g]) begin
                    sw_q[g] <= 1'b0;
                end
            end
        end
    end

    // R9: no request bit means no change to the stored vectors
    a_r9_idle_holds_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set == '0 && mask_clr == '0) |=> $stable(mask_q));
    a_r9_idle_holds_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set == '0 && sw_clr == '0) |=> $stable(sw_q));

endmodule

// File: rtl/aimc_prio_enc.sv
module aimc_prio_enc #(
    parameter int unsigned NUM_LINES = 32,
    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] live,
    output logic                 found,
    output logic [IDX_W-1:0]     win_idx
);

    // below[i] is 1 when some line with a smaller index is live
    logic [NUM_LINES-1:0] below;
    logic [NUM_LINES-1:0] first;

    assign below[0] = 1'b0;
    for (genvar g = 1; g < NUM_LINES; g++) begin : g_chain
        assign below[g] = below[g-1] | live[g-1];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_first
        assign first[g] = live[g] & ~below[g];
    end

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (first[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

    assign found = |live;

    // R4: winner is live and nothing below it is live
    a_r4_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> live[win_idx]);
    a_r4_nothing_lower: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((live & ((NUM_LINES'(1) << win_idx) - NUM_LINES'(1))) == '0));
    a_r4_single_first: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first));

endmodule

// File: rtl/aimc_event_fmt.sv
module aimc_event_fmt
    import aimc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [3:0]  DIE_ID    = 4'd0,
    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             found,
    input  logic [IDX_W-1:0] win_idx,
    output logic [31:0]      word
);

    ev_word_t ev;

    always_comb begin
        ev = '0;
        if (found) begin
            ev.kind = EV_HW;
            ev.die  = DIE_ID;
            ev.line = 16'(win_idx);
        end
    end

    assign word = ev;

endmodule

// File: rtl/auto_mask_intc.sv
module auto_mask_intc
    import aimc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [3:0]  DIE_ID    = 4'd3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] hw_irq,
    input  logic                 req,
    input  logic                 req_wr,
    input  logic [2:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data,
    output logic                 cpu_irq
);

    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    initial begin
        if (NUM_LINES < 1 || NUM_LINES > 32) begin
            $error("NUM_LINES must lie in 1..32");
        end
    end

    logic [NUM_LINES-1:0] mask_q, sw_q, raw, live;
    logic [NUM_LINES-1:0] mask_set, mask_clr, sw_set, sw_clr;
    logic                 found;
    logic [IDX_W-1:0]     win_idx;
    logic [31:0]          ev_word;
    logic                 wr_hit, rd_hit, ev_rd;
    logic [NUM_LINES-1:0] wbits;
    irq_state_e           state_q, state_d;

    assign wr_hit = req &  req_wr;
    assign rd_hit = req & ~req_wr;
    assign ev_rd  = rd_hit && (req_addr == RA_EVENT);
    assign wbits  = req_wdata[NUM_LINES-1:0];

    assign raw  = hw_irq | sw_q;
    assign live = raw & ~mask_q;

    // request decode; an event read that finds a winner masks it
    always_comb begin
        mask_set = '0;
        mask_clr = '0;
        sw_set   = '0;
        sw_clr   = '0;
        if (wr_hit) begin
            unique case (req_addr)
                RA_MASK_SET: mask_set = wbits;
                RA_MASK_CLR: mask_clr = wbits;
                RA_SW_SET:   sw_set   = wbits;
                RA_SW_CLR:   sw_clr   = wbits;
                default: ;
            endcase
        end else if (ev_rd && found) begin
            mask_set[win_idx] = 1'b1;
        end
    end

    aimc_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .mask_q   (mask_q),
        .sw_q     (sw_q)
    );

    aimc_prio_enc #(.NUM_LINES(NUM_LINES)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live),
        .found   (found),
        .win_idx (win_idx)
    );

    aimc_event_fmt #(.NUM_LINES(NUM_LINES), .DIE_ID(DIE_ID)) u_fmt (
        .found   (found),
        .win_idx (win_idx),
        .word    (ev_word)
    );

    // read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_hit;
            if (rd_hit) begin
                unique case (req_addr)
                    RA_EVENT:                rsp_data <= ev_word;
                    RA_MASK_SET, RA_MASK_CLR: rsp_data <= 32'(mask_q);
                    RA_SW_SET, RA_SW_CLR:     rsp_data <= 32'(sw_q);
                    default:                 rsp_data <= '0;
                endcase
            end
        end
    end

    // output state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (found)  state_d = ST_ALERT;
            ST_ALERT: if (!found) state_d = ST_QUIET;
            default:              state_d = ST_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        cpu_irq = (state_q == ST_ALERT);
    end

    // R6: delivered line is masked after the read
    a_r6_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && found) |=> mask_q[$past(win_idx)]);
    // R7: empty event read leaves masks alone and returns zero
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && !found) |=> ($stable(mask_q) && rsp_data == '0));
    // R8: cpu_irq follows live sources by one cycle
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|live) |=> cpu_irq);
    a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) |=> !cpu_irq);
    // R5: response valid one cycle after a read request
    a_r5_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rsp_valid);

endmodule

// File: tb/auto_mask_intc_bench.sv
module auto_mask_intc_bench;

    localparam int unsigned N = 32;
    localparam logic [3:0]  DIE = 4'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw_irq = '0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [2:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          cpu_irq;

    int n_checks = 0;
    int n_fail = 0;

    logic [N-1:0] m_mask, m_sw;

    always #5 clk = ~clk;

    auto_mask_intc #(.NUM_LINES(N), .DIE_ID(DIE)) u_auto_mask_intc (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] exp_event(input logic [N-1:0] lv);
        for (int i = 0; i < N; i++) begin
            if (lv[i]) return {4'd1, DIE, 8'd0, 16'(i)};
        end
        return 32'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; checks cpu_irq and any read data after the edge
    task automatic step(input logic r, input logic w, input logic [2:0] a,
                        input logic [31:0] d, input logic [N-1:0] hw, input string tag);
        logic [N-1:0] lv;
        logic [31:0]  exp_rd;
        @(negedge clk);
        req = r; req_wr = w; req_addr = a; req_wdata = d; hw_irq = hw;
        #1;
        lv = (hw | m_sw) & ~m_mask;
        exp_rd = '0;
        if (r && !w) begin
            case (a)
                3'd0: exp_rd = exp_event(lv);
                3'd1, 3'd2: exp_rd = m_mask;
                3'd3, 3'd4: exp_rd = m_sw;
                default: exp_rd = '0;
            endcase
        end
        @(posedge clk);
        if (r && w) begin
            case (a)
                3'd1: m_mask = m_mask | d;
                3'd2: m_mask = m_mask & ~d;
                3'd3: m_sw = m_sw | d;
                3'd4: m_sw = m_sw & ~d;
                default: ;
            endcase
        end else if (r && a == 3'd0 && lv != '0) begin
            for (int i = 0; i < N; i++) begin
                if (lv[i]) begin m_mask[i] = 1'b1; break; end
            end
        end
        #1;
        check({tag, " R8 cpu_irq"}, 32'(cpu_irq), 32'(|lv));
        check({tag, " R5 rsp_valid"}, 32'(rsp_valid), 32'(r && !w));
        if (r && !w) check({tag, " read data"}, rsp_data, exp_rd);
        req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_mask = '1; m_sw = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 cpu_irq", 32'(cpu_irq), 32'd0);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        step(1, 0, 3'd1, 0, '0, "R1 mask readback");
        step(1, 0, 3'd3, 0, '0, "R1 sw readback");

        // R3 masked lines stay silent
        step(0, 0, 0, 0, 32'hFFFF_FFFF, "R3 all high masked");
        step(1, 0, 3'd0, 0, 32'hFFFF_FFFF, "R3 event read masked");

        // R9 zero writes are no-ops
        step(1, 1, 3'd2, 32'h0, '0, "R9 zero clear");
        step(1, 0, 3'd2, 0, '0, "R9 mask after zero write");
        step(1, 1, 3'd3, 32'h0, '0, "R9 zero sw set");
        step(1, 0, 3'd4, 0, '0, "R9 sw after zero write");

        // R4 priority, R6 auto-mask, R10 re-pend after unmask
        step(1, 1, 3'd2, 32'h0000_0124, '0, "R9 unmask 2,5,8");
        step(0, 0, 0, 0, 32'h0000_0120, "R8 rise");
        step(1, 0, 3'd0, 0, 32'h0000_0124, "R4 lowest of 2,5,8");
        step(1, 0, 3'd0, 0, 32'h0000_0124, "R6 next is 5");
        step(1, 0, 3'd1, 0, 32'h0000_0124, "R6 mask readback");
        step(1, 1, 3'd2, 32'h0000_0004, 32'h0000_0124, "R10 unmask 2");
        step(1, 0, 3'd0, 0, 32'h0000_0124, "R10 line 2 again");
        step(1, 0, 3'd0, 0, 32'h0000_0100, "R6 line 8");
        step(1, 0, 3'd0, 0, 32'h0000_0100, "R7 empty read");

        // R2 software trigger ORed, level drop
        step(1, 1, 3'd2, 32'h8000_0000, '0, "R2 unmask 31");
        step(1, 1, 3'd3, 32'h8000_0000, '0, "R2 sw set 31");
        step(0, 0, 0, 0, '0, "R2 sw live");
        step(1, 1, 3'd4, 32'h8000_0000, 32'h8000_0000, "R2 sw clear hw high");
        step(0, 0, 0, 0, '0, "R2 level drop");
        step(0, 0, 0, 0, '0, "R2 idle");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [2:0]  a;
            logic [31:0] d;
            logic [N-1:0] hw;
            logic w;
            a = 3'($urandom_range(0, 5));
            d = $urandom() & $urandom();
            hw = $urandom() & $urandom() & $urandom();
            w = ($urandom_range(0, 2) == 0) && a != 3'd0;
            step($urandom_range(0, 3) != 0, w, a, d, hw, "R4 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule